// File: doc/BRIEF.md
# Double-Buffered DMA Pointer and Count Channel

This block is a single DMA channel that sits beside a serial peripheral. It has two pointer and count pairs. The active pair drives memory accesses. The standby pair is queued behind it, so that software can arm the following buffer while the active one drains. Each transfer pulse from the peripheral asks for one memory access. The channel issues it as a valid/ready request that carries the current pointer and a transfer size. The size comes from the peripheral's configured character length.

Each accepted access advances the pointer by the access width and counts the active count down by one. When the count reaches zero, the end flag rises. If the standby count is nonzero, the standby pair moves into the active pair and the standby count is cleared, so the stream continues without a gap. A combined idle flag shows when both counts are exhausted.

Software writes the four registers through a simple select-and-strobe port. It reads them back on dedicated outputs. The channel is switched on and off with set and clear pulses.

Top module: `dma_dbuf_chan`

## Requirements
- R1: `en_set` turns the channel on and `en_clr` turns it off. When both are high in the same cycle, `en_clr` wins. `chan_en` shows the state from the cycle after the pulse. The channel is off after reset.
- R2: A `trig` pulse is captured only while the channel is on and the active count is nonzero. At most one request is held. A second pulse that arrives while a request is pending and not accepted is dropped.
- R3: `mem_valid` rises in the cycle after a captured pulse. Once raised, `mem_valid` stays high with `mem_addr` unchanged until `mem_ready` is seen, unless the channel is disabled or a register is written. Exactly one access is made per captured pulse.
- R4: `xfer_size` and `mem_size` are 0 (byte, step 1) when `datlen` is 7 or less, 1 (half-word, step 2) when `datlen` is 8 to 15, and 2 (word, step 4) when `datlen` is 16 or more.
- R5: On each accepted access (`mem_valid` and `mem_ready` both high), the active pointer grows by the step and the active count drops by one. Both changes show in the next cycle.
- R6: `end_flag` rises in the cycle after an accepted access that takes the active count from 1 to 0. It falls after any write to either count register (`reg_sel` 1 or 3).
- R7: When the active count is zero and the standby count is nonzero, the standby pointer and standby count load into the active pair at the next edge, and the standby count becomes zero. This includes the edge of the access that took the count to zero.
- R8: `buf_empty` is high exactly when both counts are zero, and `mem_valid` is then low.
- R9: A register write wins over the update from an access in the same cycle. A write to the active count replaces the decrement, and the pointer still advances. A write to a count also clears `end_flag` even if that access ended the buffer.
- R10: A pulse that arrives while the active count is zero is not remembered. A later nonzero count write alone produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_set | input | 1 | Pulse: turn the channel on |
| en_clr | input | 1 | Pulse: turn the channel off (wins over en_set) |
| chan_en | output | 1 | Channel enable status |
| trig | input | 1 | Transfer pulse from the peripheral's ready condition |
| datlen | input | 5 | Character length minus one, used for the size |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 active ptr, 1 active count, 2 standby ptr, 3 standby count |
| reg_wdata | input | 32 | Write data (count registers take bits 15:0) |
| cur_ptr | output | 32 | Active pointer |
| cur_cnt | output | 16 | Active count |
| nxt_ptr | output | 32 | Standby pointer |
| nxt_cnt | output | 16 | Standby count |
| mem_valid | output | 1 | Access request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 32 | Access address |
| mem_size | output | 2 | Access size, same code as xfer_size |
| xfer_size | output | 2 | Transfer size code for the peripheral side |
| end_flag | output | 1 | Active buffer finished |
| buf_empty | output | 1 | Both counts zero |

## Verification
The results fall due at fixed times:

- **A captured pulse:** it shows on `mem_valid` one edge after the `trig` pulse.
- **An accepted access:** its pointer and count update, any reload, and `end_flag` all show one edge after the `mem_valid`/`mem_ready` handshake.
- **A register write:** it shows one edge after the strobe.
- **Combinational outputs:** `buf_empty` and the size outputs follow the registers with no extra delay.

The bench drives every input on the falling clock edge and samples half a period after the edge it is waiting for. Each check sits exactly at the first falling edge after the edge where the result is due. Back-pressure is held across several cycles to confirm the request stays unchanged.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } xfer_size_e;

  localparam logic [1:0] SEL_CUR_PTR = 2'd0;
  localparam logic [1:0] SEL_CUR_CNT = 2'd1;
  localparam logic [1:0] SEL_NXT_PTR = 2'd2;
  localparam logic [1:0] SEL_NXT_CNT = 2'd3;
endpackage

// File: rtl/dma_size_dec.sv
module dma_size_dec
  import dma_chan_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic [LEN_W-1:0] datlen,
  output xfer_size_e       size,
  output logic [2:0]       step
);
  localparam logic [LEN_W-1:0] BYTE_MAX = LEN_W'(7);
  localparam logic [LEN_W-1:0] HALF_MAX = LEN_W'(15);

  always_comb begin
    if (datlen <= BYTE_MAX) begin
      size = SZ_BYTE;
      step = 3'd1;
    end else if (datlen <= HALF_MAX) begin
      size = SZ_HALF;
      step = 3'd2;
    end else begin
      size = SZ_WORD;
      step = 3'd4;
    end
  end

  always_comb begin
    a_step_pow2_r4: assert ($countones(step) == 1);
  end
endmodule

// File: rtl/dma_req_ctl.sv
module dma_req_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_set,
  input  logic en_clr,
  input  logic trig,
  input  logic cnt_zero,
  input  logic mem_ready,
  output logic chan_en,
  output logic mem_valid,
  output logic xfer_hs
);
  logic en_q, pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (en_clr) en_q <= 1'b0;
    else if (en_set) en_q <= 1'b1;
  end

  assign mem_valid = pend_q && en_q && !cnt_zero;
  assign xfer_hs   = mem_valid && mem_ready;
  assign chan_en   = en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pend_q <= 1'b0;
    else if (!en_q || cnt_zero) pend_q <= 1'b0;
    else                        pend_q <= (pend_q && !xfer_hs) || trig;
  end

  p_en_clr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr |=> !chan_en);
  p_en_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en_set && !en_clr |=> chan_en);
  p_no_req_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> !mem_valid);
endmodule

// File: rtl/dma_buf_regs.sv
module dma_buf_regs
  import dma_chan_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [PTR_W-1:0] reg_wdata,
  input  logic             xfer_hs,
  input  logic [2:0]       step,
  output logic [PTR_W-1:0] cur_ptr,
  output logic [CNT_W-1:0] cur_cnt,
  output logic [PTR_W-1:0] nxt_ptr,
  output logic [CNT_W-1:0] nxt_cnt,
  output logic             end_flag
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             wr_cp, wr_cc, wr_np, wr_nc;
  logic [PTR_W-1:0] step_ext, ptr_after, cur_ptr_n;
  logic [CNT_W-1:0] cnt_after, cur_cnt_n, nxt_cnt_n, wcnt;
  logic             reload, end_n;

  assign wr_cp    = reg_wr && (reg_sel == SEL_CUR_PTR);
  assign wr_cc    = reg_wr && (reg_sel == SEL_CUR_CNT);
  assign wr_np    = reg_wr && (reg_sel == SEL_NXT_PTR);
  assign wr_nc    = reg_wr && (reg_sel == SEL_NXT_CNT);
  assign wcnt     = reg_wdata[CNT_W-1:0];
  assign step_ext = PTR_W'(step);

  always_comb begin
    ptr_after = wr_cp ? reg_wdata : (xfer_hs ? cur_ptr + step_ext : cur_ptr);
    cnt_after = wr_cc ? wcnt : (xfer_hs ? cur_cnt - CNT_ONE : cur_cnt);
    reload    = !wr_cp && !wr_cc && (cnt_after == '0) && (nxt_cnt != '0);
    cur_ptr_n = reload ? nxt_ptr : ptr_after;
    cur_cnt_n = reload ? nxt_cnt : cnt_after;
    nxt_cnt_n = wr_nc ? wcnt : (reload ? '0 : nxt_cnt);
    if (wr_cc || wr_nc)                     end_n = 1'b0;
    else if (xfer_hs && cur_cnt == CNT_ONE) end_n = 1'b1;
    else                                    end_n = end_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_ptr  <= '0;
      cur_cnt  <= '0;
      nxt_ptr  <= '0;
      nxt_cnt  <= '0;
      end_flag <= 1'b0;
    end else begin
      cur_ptr  <= cur_ptr_n;
      cur_cnt  <= cur_cnt_n;
      nxt_cnt  <= nxt_cnt_n;
      end_flag <= end_n;
      if (wr_np) nxt_ptr <= reg_wdata;
    end
  end

  p_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_hs && !reg_wr && cur_cnt > CNT_ONE |=>
      cur_cnt == $past(cur_cnt) - CNT_ONE && cur_ptr == $past(cur_ptr) + $past(step_ext));
  p_end_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_hs && !reg_wr && cur_cnt == CNT_ONE |=> end_flag);
  p_end_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_sel[0] |=> !end_flag);
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr && cur_cnt == '0 && nxt_cnt != '0 |=>
      cur_cnt == $past(nxt_cnt) && cur_ptr == $past(nxt_ptr) && nxt_cnt == '0);
  p_wr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cc && wcnt != '0 |=> cur_cnt == $past(wcnt));
endmodule

// File: rtl/dma_dbuf_chan.sv
module dma_dbuf_chan
  import dma_chan_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter int CNT_W = 16,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_set,
  input  logic             en_clr,
  output logic             chan_en,
  input  logic             trig,
  input  logic [LEN_W-1:0] datlen,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [PTR_W-1:0] reg_wdata,
  output logic [PTR_W-1:0] cur_ptr,
  output logic [CNT_W-1:0] cur_cnt,
  output logic [PTR_W-1:0] nxt_ptr,
  output logic [CNT_W-1:0] nxt_cnt,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [PTR_W-1:0] mem_addr,
  output logic [1:0]       mem_size,
  output logic [1:0]       xfer_size,
  output logic             end_flag,
  output logic             buf_empty
);
  xfer_size_e size_e;
  logic [2:0] step;
  logic       xfer_hs, cnt_zero;

  dma_size_dec #(.LEN_W(LEN_W)) u_dec (
    .datlen (datlen),
    .size   (size_e),
    .step   (step)
  );

  dma_req_ctl u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_set    (en_set),
    .en_clr    (en_clr),
    .trig      (trig),
    .cnt_zero  (cnt_zero),
    .mem_ready (mem_ready),
    .chan_en   (chan_en),
    .mem_valid (mem_valid),
    .xfer_hs   (xfer_hs)
  );

  dma_buf_regs #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .xfer_hs   (xfer_hs),
    .step      (step),
    .cur_ptr   (cur_ptr),
    .cur_cnt   (cur_cnt),
    .nxt_ptr   (nxt_ptr),
    .nxt_cnt   (nxt_cnt),
    .end_flag  (end_flag)
  );

  assign cnt_zero  = (cur_cnt == '0);
  assign buf_empty = cnt_zero && (nxt_cnt == '0);
  assign mem_addr  = cur_ptr;
  assign mem_size  = size_e;
  assign xfer_size = size_e;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready && !en_clr && !reg_wr |=> mem_valid && $stable(mem_addr));
  p_empty_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_empty |-> !mem_valid);
  p_zero_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_zero && !reg_wr |=> !mem_valid);
endmodule

// File: tb/dma_dbuf_chan_test.sv
module dma_dbuf_chan_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        en_set = 0, en_clr = 0, trig = 0, reg_wr = 0, mem_ready = 0;
  logic [4:0]  datlen = 5'd7;
  logic [1:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic        chan_en, mem_valid, end_flag, buf_empty;
  logic [31:0] cur_ptr, nxt_ptr, mem_addr;
  logic [15:0] cur_cnt, nxt_cnt;
  logic [1:0]  mem_size, xfer_size;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_dbuf_chan uut (
    .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr), .chan_en(chan_en),
    .trig(trig), .datlen(datlen), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cur_ptr(cur_ptr), .cur_cnt(cur_cnt), .nxt_ptr(nxt_ptr),
    .nxt_cnt(nxt_cnt), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_size(mem_size), .xfer_size(xfer_size),
    .end_flag(end_flag), .buf_empty(buf_empty)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic en_pulse(input logic s, input logic c);
    @(negedge clk); en_set = s; en_clr = c;
    @(negedge clk); en_set = 0; en_clr = 0;
  endtask

  task automatic pulse_trig;
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
  endtask

  task automatic t_reset;
    chk("R1 reset en", chan_en, 0);
    chk("R8 reset empty", buf_empty, 1);
    chk("R6 reset end", end_flag, 0);
    chk("R3 reset valid", mem_valid, 0);
  endtask

  task automatic t_enable;
    en_pulse(1, 0); chk("R1 set", chan_en, 1);
    en_pulse(1, 1); chk("R1 clr wins", chan_en, 0);
    en_pulse(1, 0); chk("R1 reset on", chan_en, 1);
  endtask

  task automatic t_size;
    datlen = 5'd7;  #1 chk("R4 len7", {30'd0, xfer_size}, 0);
    datlen = 5'd8;  #1 chk("R4 len8", {30'd0, mem_size}, 1);
    datlen = 5'd15; #1 chk("R4 len15", {30'd0, xfer_size}, 1);
    datlen = 5'd16; #1 chk("R4 len16", {30'd0, mem_size}, 2);
    datlen = 5'd31; #1 chk("R4 len31", {30'd0, xfer_size}, 2);
  endtask

  task automatic t_step;
    mem_ready = 1;
    wr(2'd0, 32'h1000); wr(2'd1, 32'd4);
    chk("R8 not empty", buf_empty, 0);
    datlen = 5'd7;
    pulse_trig;
    chk("R3 valid", mem_valid, 1);
    chk("R3 addr", mem_addr, 32'h1000);
    @(negedge clk);
    chk("R5 byte ptr", cur_ptr, 32'h1001);
    chk("R5 cnt", cur_cnt, 3);
    chk("R3 one access", mem_valid, 0);
    datlen = 5'd16;
    pulse_trig; @(negedge clk);
    chk("R5 word ptr", cur_ptr, 32'h1005);
    datlen = 5'd12;
    pulse_trig; @(negedge clk);
    chk("R5 half ptr", cur_ptr, 32'h1007);
    chk("R5 cnt2", cur_cnt, 1);
    chk("R6 no end yet", end_flag, 0);
  endtask

  task automatic t_backpressure;
    wr(2'd1, 32'd4);
    mem_ready = 0;
    pulse_trig;
    chk("R3 valid bp", mem_valid, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 hold valid", mem_valid, 1);
      chk("R3 hold addr", mem_addr, 32'h1007);
    end
    pulse_trig;
    @(negedge clk); mem_ready = 1;
    @(negedge clk);
    chk("R2 one access cnt", cur_cnt, 3);
    chk("R2 released", mem_valid, 0);
    @(negedge clk);
    chk("R2 extra dropped", cur_cnt, 3);
  endtask

  task automatic t_reload;
    wr(2'd1, 32'd1); wr(2'd2, 32'h2000); wr(2'd3, 32'd2);
    datlen = 5'd7;
    pulse_trig; @(negedge clk);
    chk("R6 end set", end_flag, 1);
    chk("R7 ptr loaded", cur_ptr, 32'h2000);
    chk("R7 cnt loaded", cur_cnt, 2);
    chk("R7 next cleared", nxt_cnt, 0);
    chk("R8 not empty", buf_empty, 0);
    wr(2'd1, 32'd2);
    chk("R6 end cleared", end_flag, 0);
  endtask

  task automatic t_empty;
    logic [31:0] p;
    pulse_trig; @(negedge clk);
    pulse_trig; @(negedge clk);
    chk("R6 end last", end_flag, 1);
    chk("R8 empty", buf_empty, 1);
    p = cur_ptr;
    pulse_trig;
    chk("R10 no req zero", mem_valid, 0);
    @(negedge clk);
    chk("R10 ptr kept", cur_ptr, p);
    wr(2'd1, 32'd1);
    chk("R10 not remembered", mem_valid, 0);
    @(negedge clk);
    chk("R10 cnt kept", cur_cnt, 1);
  endtask

  task automatic t_disabled;
    en_pulse(0, 1);
    pulse_trig;
    chk("R2 off no req", mem_valid, 0);
    @(negedge clk);
    chk("R2 off cnt", cur_cnt, 1);
    en_pulse(1, 0);
  endtask

  task automatic t_priority;
    logic [31:0] p;
    wr(2'd1, 32'd5);
    p = cur_ptr;
    datlen = 5'd7;
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0; reg_wr = 1; reg_sel = 2'd1; reg_wdata = 32'd9;
    @(negedge clk); reg_wr = 0;
    chk("R9 write wins", cur_cnt, 9);
    chk("R9 ptr advanced", cur_ptr, p + 1);
    wr(2'd1, 32'd1);
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0; reg_wr = 1; reg_sel = 2'd3; reg_wdata = 32'd0;
    @(negedge clk); reg_wr = 0;
    chk("R9 end suppressed", end_flag, 0);
    chk("R9 cnt zero", cur_cnt, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #1 t_reset;
    rst_n = 1;
    t_enable;
    t_size;
    t_step;
    t_backpressure;
    t_reload;
    t_empty;
    t_disabled;
    t_priority;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule